// File: doc/BRIEF.md
# Phase Accumulator Bank With Absolute/Relative Phase Update

This block holds three numerically controlled phase accumulators for a generator that drives several oscillators. Each accumulator adds its own frequency word on every sample clock and wraps modulo 2^AW. The block reports a registered phase word for each oscillator. That word is the top PW bits of the accumulator plus a stored phase offset.

Each accumulator can take a phase command, and a per-accumulator mode bit chooses how the command is applied. In absolute mode the command zeroes the accumulator, so the reported phase equals the commanded value exactly. In relative mode the command only replaces the offset, and the accumulator keeps running. A small three-bit mode register sits at a configuration address and sets the mode bits. Its bit order is not the accumulator order.

Top module: `phase_bank`

## Requirements
- R1: While `rst` is high, every `phase_out` field reads 0 and all three accumulators are set to absolute mode (mode register value 3'b111).
- R2: Each accumulator adds its frequency word every clock, modulo 2^32. The `phase_out` field after a clock edge equals the top 16 bits of (accumulator + offset) as they stand after that edge, so an input shows at the output one clock later.
- R3: In absolute mode, a phase command with value C gives a `phase_out` field of exactly C in the cycle after the command.
- R4: In relative mode, a phase command with value C sets the offset to C·2^16 and leaves the accumulator running. The output becomes the top 16 bits of (acc + freq + C·2^16).
- R5: After an absolute command, the accumulator restarts from zero and adds the frequency word in the next cycle. The output then equals the top 16 bits of (C·2^16 + freq).
- R6: The mode register is written only when `cfg_we` is 1 and `cfg_addr` equals 1. A write to any other address leaves every mode unchanged.
- R7: Mode register bit 0 selects absolute mode (1) or relative mode (0) for accumulator 1. Bit 1 does the same for accumulator 2, and bit 2 for accumulator 0.
- R8: A phase command in the same cycle as a mode register write uses the mode held before that write.
- R9: Without commands, each output keeps tracking its accumulator plus the offset from its last command, and the offset persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address; the mode register is at 1 |
| cfg_data | input | 3 | Mode register write data |
| freq_word | input | 96 | Three 32-bit frequency words; accumulator k at bits [32k+31:32k] |
| ph_valid | input | 3 | Phase command strobe, one bit per accumulator |
| ph_value | input | 48 | Three 16-bit phase commands; accumulator k at bits [16k+15:16k] |
| phase_out | output | 48 | Three registered 16-bit phases; accumulator k at bits [16k+15:16k] |

## Verification
The bench uses the default widths: a 32-bit accumulator, 16-bit phase words and a 4-bit configuration address. With these widths, frequency words near 2^32 wrap the accumulator within a few cycles, and offsets near full scale make the offset sum wrap as well. Both wraps fall inside a short run. Random configuration writes go to every address value, so ignored addresses and every mode bit pattern occur. The directed cases cover the scrambled bit order and the case of a write and a command in the same cycle.

// File: rtl/phase_bank_pkg.sv
package phase_bank_pkg;
  localparam int NUM_ACC  = 3;
  localparam int MODE_ADR = 1;

  // mode register bit that controls accumulator k: 0->2, 1->0, 2->1
  function automatic int mode_bit_of(input int k);
    return (k + 2) % NUM_ACC;
  endfunction
endpackage

// File: rtl/phase_mode_reg.sv
module phase_mode_reg
  import phase_bank_pkg::*;
#(
  parameter int ADR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADR_W-1:0]   wr_addr,
  input  logic [NUM_ACC-1:0] wr_data,
  output logic [NUM_ACC-1:0] abs_mode
);
  logic [NUM_ACC-1:0] raw_q;
  logic               hit;

  assign hit = wr_en && (wr_addr == ADR_W'(MODE_ADR));

  always_ff @(posedge clk) begin
    if (rst)      raw_q <= '1;
    else if (hit) raw_q <= wr_data;
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_map
    assign abs_mode[k] = raw_q[mode_bit_of(k)];
  end

  // R6: other addresses do not disturb the modes
  p_ignore_addr_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADR_W'(MODE_ADR)) |=> $stable(abs_mode));

  // R1: modes come out of reset as all absolute
  p_reset_abs_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (abs_mode == '1));
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] freq,
  input  logic          cmd_valid,
  input  logic [PW-1:0] cmd_value,
  input  logic          abs_mode,
  output logic [PW-1:0] phase_o
);
  localparam int SH = AW - PW;

  logic [AW-1:0] acc_q, off_q, acc_d, off_d, sum_d;

  always_comb begin
    acc_d = acc_q + freq;
    off_d = off_q;
    if (cmd_valid) begin
      off_d = {cmd_value, {SH{1'b0}}};
      if (abs_mode) acc_d = '0;
    end
    sum_d = acc_d + off_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      off_q   <= '0;
      phase_o <= '0;
    end else begin
      acc_q   <= acc_d;
      off_q   <= off_d;
      phase_o <= sum_d[AW-1:SH];
    end
  end

  // R3: absolute command appears exactly at the output
  p_abs_exact_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cmd_valid && abs_mode)) |-> (phase_o == $past(cmd_value)));

  // R5: restart from zero, then one frequency step
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(cmd_valid && abs_mode, 2) && !$past(cmd_valid))
      |-> (phase_o == PW'(({$past(cmd_value, 2), {SH{1'b0}}} + $past(freq)) >> SH)));

  // R1: output is zero straight out of reset
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_o == '0));
endmodule

// File: rtl/phase_bank.sv
module phase_bank
  import phase_bank_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PW    = 16,
  parameter int ADR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [ADR_W-1:0]       cfg_addr,
  input  logic [NUM_ACC-1:0]     cfg_data,
  input  logic [NUM_ACC*AW-1:0]  freq_word,
  input  logic [NUM_ACC-1:0]     ph_valid,
  input  logic [NUM_ACC*PW-1:0]  ph_value,
  output logic [NUM_ACC*PW-1:0]  phase_out
);
  logic [NUM_ACC-1:0] abs_mode;

  phase_mode_reg #(.ADR_W(ADR_W)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .abs_mode (abs_mode)
  );

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    phase_accum #(.AW(AW), .PW(PW)) u_acc (
      .clk       (clk),
      .rst       (rst),
      .freq      (freq_word[k*AW +: AW]),
      .cmd_valid (ph_valid[k]),
      .cmd_value (ph_value[k*PW +: PW]),
      .abs_mode  (abs_mode[k]),
      .phase_o   (phase_out[k*PW +: PW])
    );
  end
endmodule

// File: tb/phase_bank_tb_top.sv
module phase_bank_tb_top;
  logic        clk = 0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [2:0]  cfg_data;
  logic [95:0] freq_word;
  logic [2:0]  ph_valid;
  logic [47:0] ph_value;
  logic [47:0] phase_out;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_acc [3];
  logic [31:0] m_off [3];
  logic        m_abs [3];
  logic [15:0] m_out [3];

  always #4 clk = ~clk;

  phase_bank dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .freq_word(freq_word), .ph_valid(ph_valid), .ph_value(ph_value), .phase_out(phase_out)
  );

  function automatic logic [15:0] top16(input logic [31:0] x);
    return x[31:16];
  endfunction

  task automatic check(input string tag, input int k, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s acc%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_acc[k] = 0; m_off[k] = 0; m_abs[k] = 1; m_out[k] = 0;
    end
  endtask

  // called at a negedge: drive, advance model, sample after posedge
  task automatic step(input string tag, input logic we, input logic [3:0] a, input logic [2:0] d,
                      input logic [2:0] v, input logic [47:0] c, input logic [95:0] f);
    cfg_we = we; cfg_addr = a; cfg_data = d; ph_valid = v; ph_value = c; freq_word = f;
    for (int k = 0; k < 3; k++) begin
      m_acc[k] = m_acc[k] + f[k*32 +: 32];
      if (v[k]) begin
        m_off[k] = {c[k*16 +: 16], 16'h0};
        if (m_abs[k]) m_acc[k] = 0;
      end
      m_out[k] = top16(m_acc[k] + m_off[k]);
    end
    if (we && a == 4'd1) begin
      m_abs[0] = d[2]; m_abs[1] = d[0]; m_abs[2] = d[1];
    end
    @(posedge clk); #2;
    for (int k = 0; k < 3; k++) check(tag, k, phase_out[k*16 +: 16], m_out[k]);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic [95:0] f, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, f);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [95:0] fw;
    void'($urandom(32'h5eed_1234));
    rst = 1; cfg_we = 0; cfg_addr = 0; cfg_data = 0; ph_valid = 0; ph_value = 0;
    freq_word = {32'h0003_0000, 32'h0002_0000, 32'h0001_0000};
    model_reset();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) check("R1", k, phase_out[k*16 +: 16], 16'h0);
    rst = 0;

    fw = {32'h0003_0000, 32'h0002_0000, 32'h0001_0000};
    idle("R2", fw, 4);
    // R1: default absolute mode on all three
    step("R1", 0, 0, 0, 3'b111, {16'h1111, 16'h2222, 16'h3333}, fw);
    // R5: restart from the command value plus one step
    step("R5", 0, 0, 0, 0, 0, fw);
    // R2: wrap with large frequency words
    fw = {32'hFFFF_FFFF, 32'hF000_0001, 32'h8000_0003};
    idle("R2", fw, 6);
    // R3: absolute gives exact value despite large step
    step("R3", 0, 0, 0, 3'b111, {16'hFFFF, 16'h8000, 16'h0001}, fw);
    // R6: write to other address ignored, modes stay absolute
    step("R6", 1, 4'd0, 3'b000, 0, 0, fw);
    step("R6", 1, 4'd9, 3'b000, 0, 0, fw);
    step("R6", 0, 0, 0, 3'b111, {16'h0A0A, 16'h0B0B, 16'h0C0C}, fw);
    // R7: value 3'b001 -> acc1 absolute, acc0 and acc2 relative
    step("R7", 1, 4'd1, 3'b001, 0, 0, fw);
    step("R7", 0, 0, 0, 3'b111, {16'h4444, 16'h5555, 16'h6666}, fw);
    step("R7", 1, 4'd1, 3'b110, 0, 0, fw);
    step("R7", 0, 0, 0, 3'b111, {16'h7777, 16'h1234, 16'h4321}, fw);
    // R4: all relative, offset near full scale
    step("R4", 1, 4'd1, 3'b000, 0, 0, fw);
    step("R4", 0, 0, 0, 3'b111, {16'hFFF0, 16'h7FFF, 16'h8001}, fw);
    // R9: offset persists
    idle("R9", fw, 5);
    // R8: write to absolute in same cycle as command, still relative
    step("R8", 1, 4'd1, 3'b111, 3'b111, {16'h0102, 16'h0304, 16'h0506}, fw);
    step("R8", 0, 0, 0, 3'b111, {16'h0102, 16'h0304, 16'h0506}, fw);

    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [3:0] a;
      we = ($urandom % 8) == 0;
      a = ($urandom % 3 == 0) ? 4'd1 : 4'($urandom);
      if (i % 200 == 0) fw = {$urandom, $urandom, $urandom};
      step("R9", we, a, 3'($urandom), 3'($urandom & $urandom), {$urandom, $urandom}, fw);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule